// File: doc/BRIEF.md
# Host Command and Event Status Controller

This block is the host-side control point of a network adapter. The host writes 16-bit command words to one register offset and reads a status word back from the same offset. Each command word packs a 5-bit opcode into its top bits and an 11-bit argument below it. The block decodes these commands and acts on them:

- it keeps the current register-window number;
- it turns the receiver and transmitter on and off;
- it emits one-cycle reset and discard pulses toward the data-path units;
- it holds a command-busy flag while a reset completes.

Event sources elsewhere in the adapter signal completions with one-cycle pulses. The block latches each pulse into a pending bit and keeps it until the host acknowledges it. Two masks, both written by command, shape what the host sees. The status-enable mask decides which pending bits appear in the status word. Both masks together decide whether the interrupt line is raised.

A typical host driver does the following: select a window, program both masks, enable the receiver and transmitter, and then service interrupts by reading status and acknowledging the bits it has handled. After a receive or transmit reset, the driver polls the busy bit until it clears.

Top module: `hctl_cmd_status`

## Requirements
- R1: A write is a command only when `bus_wr` is high and `bus_addr` equals 0xE. Writes to any other offset change nothing, and `bus_rdata` reads 0 at any offset other than 0xE.
- R2: Opcode 1 (`bus_wdata[15:11]`) loads the window number from argument bits 2:0. The new window appears on `win_o` and in status bits 15:13 one cycle after the write.
- R3: Each `evt_i[k]` pulse sets pending bit k (k = 0..10). The bit stays set until an acknowledge or a total reset clears it.
- R4: Opcode 13 clears exactly the pending bits that are set in argument bits 10:0. If an event pulse arrives in the same cycle as the acknowledge of its bit, the event wins and the bit stays set.
- R5: Status bits 10:0 show the pending bits ANDed with the status-enable mask, which opcode 15 loads from the argument. Bit 11 mirrors `dma_busy_i`, bit 12 shows command busy, and bits 15:13 show the window. A mask of zero hides every event.
- R6: `irq_o` is high exactly when some pending bit is set in both the status-enable mask and the interrupt-enable mask. Opcode 14 loads the interrupt-enable mask.
- R7: Opcode 5 (receive reset) and opcode 11 (transmit reset) each do three things:
  - pulse `rx_rst_o` or `tx_rst_o` for one cycle;
  - clear the matching enable;
  - hold `cmd_busy_o` high for exactly BUSY_CYCLES cycles (default 16), starting the cycle after the write.
  A further reset command reloads the count.
- R8: Opcode 0 (total reset) does the following:
  - sets the window to 0;
  - clears both masks, both enables and all pending bits (a same-cycle event still latches);
  - pulses `total_rst_o`;
  - starts the same busy interval as R7.
- R9: Opcodes 4 and 3 set and clear `rx_en_o`. Opcodes 9 and 10 set and clear `tx_en_o`.
- R10: Opcode 8 pulses `rx_drop_o` for one cycle and does not set busy.
- R11: After reset, every output is 0, including the status word.
- R12: Opcodes not listed in R2–R10 (2, 6, 7, 12, 16–31) change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Host register offset |
| bus_wr | input | 1 | Host write strobe |
| bus_wdata | input | 16 | Host write data (command word) |
| bus_rdata | output | 16 | Status word at offset 0xE, otherwise 0 |
| evt_i | input | 11 | Single-cycle event pulses, bit k maps to status bit k |
| dma_busy_i | input | 1 | DMA engine busy level, shown in status bit 11 |
| irq_o | output | 1 | Interrupt request |
| cmd_busy_o | output | 1 | Command in progress |
| win_o | output | 3 | Current register window |
| rx_en_o | output | 1 | Receiver enable |
| tx_en_o | output | 1 | Transmitter enable |
| rx_rst_o | output | 1 | Receive reset pulse |
| tx_rst_o | output | 1 | Transmit reset pulse |
| total_rst_o | output | 1 | Total reset pulse |
| rx_drop_o | output | 1 | Receive discard pulse |

## Verification
The assertions check on every cycle the one-cycle consequences of single commands:

- a window select lands on `win_o`;
- total reset zeroes the window and raises busy;
- a reset command raises busy;
- each pulse output traces back to its own command;
- a full acknowledge with no incoming events drops the interrupt;
- off-offset writes leave the window alone.

Only the bench's scenarios can show the rest, because each depends on history across many cycles:

- how long busy lasts and how a further reset reloads it;
- how the two masks combine over sequences of events;
- that an event beats a same-cycle acknowledge;
- that unused opcodes leave state intact.

// File: rtl/hcs_pkg.sv
package hcs_pkg;

    localparam int EVT_W  = 11;
    localparam int WIN_W  = 3;
    localparam int WORD_W = 16;
    localparam int OP_LSB = 11;

    localparam logic [4:0] OP_TOTAL_RST = 5'd0;
    localparam logic [4:0] OP_SEL_WIN   = 5'd1;
    localparam logic [4:0] OP_RX_OFF    = 5'd3;
    localparam logic [4:0] OP_RX_ON     = 5'd4;
    localparam logic [4:0] OP_RX_RST    = 5'd5;
    localparam logic [4:0] OP_RX_DROP   = 5'd8;
    localparam logic [4:0] OP_TX_ON     = 5'd9;
    localparam logic [4:0] OP_TX_OFF    = 5'd10;
    localparam logic [4:0] OP_TX_RST    = 5'd11;
    localparam logic [4:0] OP_ACK       = 5'd13;
    localparam logic [4:0] OP_SET_IEN   = 5'd14;
    localparam logic [4:0] OP_SET_SEN   = 5'd15;

    typedef struct packed {
        logic             total_rst;
        logic             sel_win;
        logic             rx_off;
        logic             rx_on;
        logic             rx_rst;
        logic             rx_drop;
        logic             tx_on;
        logic             tx_off;
        logic             tx_rst;
        logic             ack;
        logic             set_ien;
        logic             set_sen;
        logic [EVT_W-1:0] arg;
    } cmd_t;

endpackage

// File: rtl/hcs_cmd_decode.sv
module hcs_cmd_decode
    import hcs_pkg::*;
#(
    parameter int          ADDR_W     = 4,
    parameter int unsigned CMD_OFFSET = 14
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output cmd_t              cmd
);

    logic       hit;
    logic [4:0] op;

    assign hit = bus_wr && (bus_addr == ADDR_W'(CMD_OFFSET));
    assign op  = bus_wdata[WORD_W-1:OP_LSB];

    always_comb begin
        cmd           = '0;
        cmd.arg       = bus_wdata[EVT_W-1:0];
        if (hit) begin
            cmd.total_rst = (op == OP_TOTAL_RST);
            cmd.sel_win   = (op == OP_SEL_WIN);
            cmd.rx_off    = (op == OP_RX_OFF);
            cmd.rx_on     = (op == OP_RX_ON);
            cmd.rx_rst    = (op == OP_RX_RST);
            cmd.rx_drop   = (op == OP_RX_DROP);
            cmd.tx_on     = (op == OP_TX_ON);
            cmd.tx_off    = (op == OP_TX_OFF);
            cmd.tx_rst    = (op == OP_TX_RST);
            cmd.ack       = (op == OP_ACK);
            cmd.set_ien   = (op == OP_SET_IEN);
            cmd.set_sen   = (op == OP_SET_SEN);
        end
    end

endmodule

// File: rtl/hcs_event_latch.sv
module hcs_event_latch #(
    parameter int N = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_all,
    input  logic [N-1:0] ack_mask,
    input  logic [N-1:0] evt,
    output logic [N-1:0] pending
);

    logic [N-1:0] pend_d, pend_q;

    for (genvar k = 0; k < N; k++) begin : g_bit
        // a new event overrides any clear in the same cycle
        always_comb begin
            if (evt[k])
                pend_d[k] = 1'b1;
            else if (clr_all || ack_mask[k])
                pend_d[k] = 1'b0;
            else
                pend_d[k] = pend_q[k];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pending = pend_q;

endmodule

// File: rtl/hcs_busy_timer.sv
module hcs_busy_timer #(
    parameter int BUSY_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)
            cnt_d = CNT_W'(BUSY_CYCLES);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/hctl_cmd_status.sv
module hctl_cmd_status
    import hcs_pkg::*;
#(
    parameter int          ADDR_W      = 4,
    parameter int unsigned CMD_OFFSET  = 14,
    parameter int          BUSY_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic [10:0]       evt_i,
    input  logic              dma_busy_i,
    output logic              irq_o,
    output logic              cmd_busy_o,
    output logic [2:0]        win_o,
    output logic              rx_en_o,
    output logic              tx_en_o,
    output logic              rx_rst_o,
    output logic              tx_rst_o,
    output logic              total_rst_o,
    output logic              rx_drop_o
);

    typedef struct packed {
        logic [WIN_W-1:0] win;
        logic [EVT_W-1:0] sen;
        logic [EVT_W-1:0] ien;
        logic             rx_en;
        logic             tx_en;
        logic             rx_rst;
        logic             tx_rst;
        logic             total_rst;
        logic             rx_drop;
    } ctl_t;

    cmd_t             cmd;
    ctl_t             ctl_d, ctl_q;
    logic [EVT_W-1:0] pending;
    logic [EVT_W-1:0] visible;
    logic             busy;
    logic             busy_start;
    logic [EVT_W-1:0] ack_mask;

    hcs_cmd_decode #(
        .ADDR_W     (ADDR_W),
        .CMD_OFFSET (CMD_OFFSET)
    ) u_dec (
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cmd       (cmd)
    );

    assign ack_mask   = cmd.ack ? cmd.arg : '0;
    assign busy_start = cmd.total_rst | cmd.rx_rst | cmd.tx_rst;

    hcs_event_latch #(.N(EVT_W)) u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_all  (cmd.total_rst),
        .ack_mask (ack_mask),
        .evt      (evt_i),
        .pending  (pending)
    );

    hcs_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
        .clk   (clk),
        .rst_n (rst_n),
        .start (busy_start),
        .busy  (busy)
    );

    always_comb begin
        ctl_d           = ctl_q;
        ctl_d.rx_rst    = cmd.rx_rst;
        ctl_d.tx_rst    = cmd.tx_rst;
        ctl_d.total_rst = cmd.total_rst;
        ctl_d.rx_drop   = cmd.rx_drop;
        if (cmd.total_rst) begin
            ctl_d.win   = '0;
            ctl_d.sen   = '0;
            ctl_d.ien   = '0;
            ctl_d.rx_en = 1'b0;
            ctl_d.tx_en = 1'b0;
        end
        if (cmd.sel_win) ctl_d.win   = cmd.arg[WIN_W-1:0];
        if (cmd.set_sen) ctl_d.sen   = cmd.arg;
        if (cmd.set_ien) ctl_d.ien   = cmd.arg;
        if (cmd.rx_on)   ctl_d.rx_en = 1'b1;
        if (cmd.rx_off || cmd.rx_rst) ctl_d.rx_en = 1'b0;
        if (cmd.tx_on)   ctl_d.tx_en = 1'b1;
        if (cmd.tx_off || cmd.tx_rst) ctl_d.tx_en = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign visible = pending & ctl_q.sen;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(CMD_OFFSET))
            bus_rdata = {ctl_q.win, busy, dma_busy_i, visible};
    end

    assign irq_o       = |(visible & ctl_q.ien);
    assign cmd_busy_o  = busy;
    assign win_o       = ctl_q.win;
    assign rx_en_o     = ctl_q.rx_en;
    assign tx_en_o     = ctl_q.tx_en;
    assign rx_rst_o    = ctl_q.rx_rst;
    assign tx_rst_o    = ctl_q.tx_rst;
    assign total_rst_o = ctl_q.total_rst;
    assign rx_drop_o   = ctl_q.rx_drop;

endmodule

// File: rtl/hcs_checks.sv
module hcs_checks #(
    parameter int          ADDR_W     = 4,
    parameter int unsigned CMD_OFFSET = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [15:0]       bus_wdata,
    input logic [10:0]       evt_i,
    input logic              irq_o,
    input logic              cmd_busy_o,
    input logic [2:0]        win_o,
    input logic              rx_en_o,
    input logic              rx_rst_o,
    input logic              tx_rst_o,
    input logic              total_rst_o,
    input logic              rx_drop_o
);

    logic       is_cmd;
    logic [4:0] op;

    assign is_cmd = bus_wr && (bus_addr == ADDR_W'(CMD_OFFSET));
    assign op     = bus_wdata[15:11];

    a_r1_offset_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr != ADDR_W'(CMD_OFFSET)) |=> $stable(win_o));

    a_r2_window_load: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmd && op == 5'd1) |=> (win_o == $past(bus_wdata[2:0])));

    a_r4_full_ack_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmd && op == 5'd13 && bus_wdata[10:0] == 11'h7FF && evt_i == '0) |=> !irq_o);

    a_r7_reset_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmd && (op == 5'd5 || op == 5'd11)) |=> cmd_busy_o);

    a_r7_tx_pulse_source: assert property (@(posedge clk) disable iff (!rst_n)
        tx_rst_o |-> $past(is_cmd && op == 5'd11));

    a_r7_rx_pulse_source: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rst_o |-> $past(is_cmd && op == 5'd5));

    a_r8_total_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmd && op == 5'd0) |=> (win_o == 3'd0 && !irq_o && cmd_busy_o && total_rst_o));

    a_r9_rx_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmd && op == 5'd4) |=> rx_en_o);

    a_r10_drop_source: assert property (@(posedge clk) disable iff (!rst_n)
        rx_drop_o |-> $past(is_cmd && op == 5'd8));

endmodule

bind hctl_cmd_status hcs_checks #(
    .ADDR_W     (ADDR_W),
    .CMD_OFFSET (CMD_OFFSET)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .evt_i       (evt_i),
    .irq_o       (irq_o),
    .cmd_busy_o  (cmd_busy_o),
    .win_o       (win_o),
    .rx_en_o     (rx_en_o),
    .rx_rst_o    (rx_rst_o),
    .tx_rst_o    (tx_rst_o),
    .total_rst_o (total_rst_o),
    .rx_drop_o   (rx_drop_o)
);

// File: tb/hctl_cmd_status_tb.sv
`timescale 1ns/1ps
module hctl_cmd_status_tb;

    localparam int BUSY = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = 4'd0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic [10:0] evt_i = 11'd0;
    logic        dma_busy_i = 1'b0;
    logic        irq_o, cmd_busy_o, rx_en_o, tx_en_o;
    logic        rx_rst_o, tx_rst_o, total_rst_o, rx_drop_o;
    logic [2:0]  win_o;

    int total = 0;
    int bad = 0;

    // behavioural reference state
    int m_win = 0, m_sen = 0, m_ien = 0, m_pend = 0, m_busy = 0;
    int m_rxen = 0, m_txen = 0, m_rxrst = 0, m_txrst = 0, m_tot = 0, m_drop = 0;

    always #2 clk = ~clk;

    hctl_cmd_status #(.BUSY_CYCLES(BUSY)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_i(evt_i),
        .dma_busy_i(dma_busy_i), .irq_o(irq_o), .cmd_busy_o(cmd_busy_o),
        .win_o(win_o), .rx_en_o(rx_en_o), .tx_en_o(tx_en_o),
        .rx_rst_o(rx_rst_o), .tx_rst_o(tx_rst_o), .total_rst_o(total_rst_o),
        .rx_drop_o(rx_drop_o)
    );

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic int exp_rdata(input int addr, input int dma);
        if (addr != 14) return 0;
        return (m_win << 13) | ((m_busy > 0 ? 1 : 0) << 12) | (dma << 11) | (m_pend & m_sen);
    endfunction

    task automatic compare_all(input string tag);
        chk({tag, " rdata"}, int'(bus_rdata), exp_rdata(int'(bus_addr), int'(dma_busy_i)));
        chk("R6 irq", int'(irq_o), ((m_pend & m_sen & m_ien) != 0) ? 1 : 0);
        chk("R7 busy", int'(cmd_busy_o), m_busy > 0 ? 1 : 0);
        chk("R2 win", int'(win_o), m_win);
        chk("R9 rx_en", int'(rx_en_o), m_rxen);
        chk("R9 tx_en", int'(tx_en_o), m_txen);
        chk("R7 rx_rst pulse", int'(rx_rst_o), m_rxrst);
        chk("R7 tx_rst pulse", int'(tx_rst_o), m_txrst);
        chk("R8 total pulse", int'(total_rst_o), m_tot);
        chk("R10 drop pulse", int'(rx_drop_o), m_drop);
    endtask

    task automatic model_step(input int wr, input int addr, input int data, input int evt);
        int op, arg, ack, clr, start;
        op = (data >> 11) & 31;
        arg = data & 'h7FF;
        ack = 0; clr = 0; start = 0;
        m_rxrst = 0; m_txrst = 0; m_tot = 0; m_drop = 0;
        if (wr != 0 && addr == 14) begin
            case (op)
                0:  begin m_win = 0; m_sen = 0; m_ien = 0; m_rxen = 0; m_txen = 0;
                          clr = 1; start = 1; m_tot = 1; end
                1:  m_win = arg & 7;
                3:  m_rxen = 0;
                4:  m_rxen = 1;
                5:  begin m_rxrst = 1; m_rxen = 0; start = 1; end
                8:  m_drop = 1;
                9:  m_txen = 1;
                10: m_txen = 0;
                11: begin m_txrst = 1; m_txen = 0; start = 1; end
                13: ack = arg;
                14: m_ien = arg;
                15: m_sen = arg;
                default: ;
            endcase
        end
        m_pend = ((clr != 0) ? 0 : (m_pend & ~ack)) | evt;
        m_pend = m_pend & 'h7FF;
        if (start != 0) m_busy = BUSY;
        else if (m_busy > 0) m_busy = m_busy - 1;
    endtask

    task automatic cyc(input int wr, input int addr, input int data, input int evt,
                       input int dma, input string tag);
        bus_wr = wr[0]; bus_addr = addr[3:0]; bus_wdata = data[15:0];
        evt_i = evt[10:0]; dma_busy_i = dma[0];
        @(posedge clk); #1;
        model_step(wr, addr, data, evt);
        compare_all(tag);
    endtask

    task automatic cmd(input int op, input int arg, input string tag);
        cyc(1, 14, (op << 11) | (arg & 'h7FF), 0, 0, tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(0, 14, 0, 0, 0, tag);
    endtask

    initial begin
        #400000;
        bad++; total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        bus_addr = 4'd14;
        #0.5;
        // R11: reset state
        compare_all("R11");
        chk("R11 rdata zero", int'(bus_rdata), 0);

        // R1: off-offset write ignored, rdata zero elsewhere
        cyc(1, 12, (1 << 11) | 5, 0, 0, "R1");
        cyc(0, 3, 0, 0, 0, "R1");
        cmd(1, 5, "R1");
        // R2: only low argument bits used
        cmd(1, 'h7FF, "R2");
        cmd(1, 2, "R2");

        // R5: events hidden under zero status mask
        cyc(0, 14, 0, 'h015, 1, "R3");
        idle(2, "R5");
        cmd(15, 'h7FF, "R5");
        cyc(0, 14, 0, 0, 1, "R5");
        cmd(15, 'h014, "R5");
        // R6: interrupt mask
        cmd(14, 'h001, "R6");
        cmd(14, 'h004, "R6");
        cyc(0, 14, 0, 'h400, 0, "R3");
        cmd(15, 'h7FF, "R6");
        // R4: partial ack, then ack with a same-cycle event
        cmd(13, 'h010, "R4");
        cyc(1, 14, (13 << 11) | 'h404, 'h004, 0, "R4");
        idle(1, "R4");
        cmd(13, 'h7FF, "R4");

        // R9: enables
        cmd(4, 0, "R9");
        cmd(9, 0, "R9");
        cmd(3, 0, "R9");
        cmd(4, 0, "R9");
        cmd(10, 0, "R9");
        cmd(9, 0, "R9");
        // R10: discard pulse without busy
        cmd(8, 0, "R10");
        idle(1, "R10");
        // R7: transmit reset, busy interval, reload by receive reset
        cmd(11, 0, "R7");
        idle(10, "R7");
        cmd(5, 0, "R7");
        idle(BUSY + 3, "R7");
        cmd(11, 0, "R7");
        cmd(11, 0, "R7");
        idle(BUSY + 2, "R7");

        // R12: unused opcodes change nothing
        cmd(4, 0, "R12");
        cmd(15, 'h3FF, "R12");
        cmd(14, 'h3FF, "R12");
        cyc(0, 14, 0, 'h0C3, 0, "R12");
        for (int op = 2; op < 32; op++) begin
            if (op == 2 || op == 6 || op == 7 || op == 12 || op >= 16)
                cmd(op, 'h7FF, "R12");
        end

        // R8: total reset with a same-cycle event
        cmd(1, 6, "R8");
        cyc(1, 14, 0, 'h002, 0, "R8");
        cmd(15, 'h7FF, "R8");
        idle(BUSY + 1, "R8");
        cyc(0, 14, 0, 'h7FF, 1, "R3");
        cmd(14, 'h7FF, "R6");
        cmd(13, 'h7FF, "R4");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule